// File: doc/BRIEF.md
# Function-Unit Hazard Matrix

This block keeps the ordering hazards among the function units of an out-of-order issue core. It has one row and one column per unit, and every crossing is a one-bit latch. When a unit is issued it records which in-flight units it must wait for before reading operands and before writing its result. The block then releases per-unit read and write grants only when those latches have drained. Load and store units are simply rows like any other.

A unit that has not yet ruled out an exception holds its write line off, so results reach architectural state precisely. A unit on a speculative path holds its write line off in the same way. A wrong-path unit is removed with a kill line, which frees its row and releases its dependents. An in-order flag on issue adds a write dependency on every unit already in flight. Results then commit in program order, and only the oldest unit can write. Execution, register storage and memory access belong to other blocks.

Top module: `fu_dep_matrix`

## Requirements
- R1: An issue (`issue_valid`=1, `issue_unit` a binary unit index) is accepted only if that unit is idle and is not being completed or killed in the same cycle. An accepted issue sets `busy` for the unit from the next cycle on. An issue aimed at a busy unit changes nothing.
- R2: On issue, a dependency bit j (bit j of a vector names unit j) is recorded only if unit j is busy and is not being completed or killed in that cycle. A bit that names the issuing unit itself is ignored.
- R3: `go_rd[i]` is 1 exactly when unit i is busy, `rd_req[i]` is 1 and no read dependency of unit i remains.
- R4: `go_wr[i]` is 1 exactly when unit i is busy, `wr_req[i]` is 1, `hold[i]` is 0 and neither a read dependency nor a write dependency of unit i remains.
- R5: `hold[i]`=1 forces `go_wr[i]` to 0 and has no effect on `go_rd[i]`.
- R6: `done[i]` on a busy unit clears its `busy` and its own dependencies. In the same cycle it clears column i in every row, so its dependents see the release on the next cycle.
- R7: `kill[i]` frees unit i exactly as `done[i]` does. Killing an idle unit changes no state.
- R8: With `issue_in_order`=1, the issuing unit also takes a write dependency on every unit that is busy and not clearing at that moment.
- R9: While `rst_n` is 0 at a clock edge, every unit becomes idle with no dependencies, so all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Issue request |
| issue_unit | input | $clog2(N) | Binary index of the unit being issued |
| issue_rd_dep | input | N | Units whose results must exist before this unit reads |
| issue_wr_dep | input | N | Units that must write before this unit writes |
| issue_in_order | input | 1 | Add a write dependency on all units in flight |
| rd_req | input | N | Per-unit request to read operands |
| wr_req | input | N | Per-unit request to write a buffered result |
| hold | input | N | Per-unit write prevention (exception or speculation) |
| done | input | N | Per-unit completion, frees the row and column |
| kill | input | N | Per-unit wrong-path kill, frees the row and column |
| go_rd | output | N | Read grant per unit |
| go_wr | output | N | Write (commit) grant per unit |
| busy | output | N | Unit holds an in-flight instruction |

## Verification
A latch that fails to set lets a grant through one or more cycles early. It shows on `go_rd` or `go_wr` in the first cycle after issue in which the request line is raised. A latch that fails to clear holds a grant low forever after the producer's `done` or `kill`, and this is visible one cycle after that clear. A wrong `busy` flag shows at once on the `busy` port, and also as a grant that appears with no request behind it or that never appears. The reference model compares all three vectors every cycle, so a bad state is reported in the cycle where it first reaches a port.

// File: rtl/fudm_pkg.sv
// Shared constants for the function-unit hazard matrix.
// Assumes: nothing; only defaults live here.
package fudm_pkg;
    localparam int unsigned DEF_UNITS = 8;
endpackage

// File: rtl/fudm_row.sv
// One row of the hazard matrix: the busy flag and the read and write
// dependency latches of a single function unit.
// Assumes: the caller masks self and non-busy bits out of the init vectors,
// and never asserts load while the unit is busy.
module fudm_row #(
    parameter int unsigned N = fudm_pkg::DEF_UNITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         clr_self,
    input  logic [N-1:0] clr_col,
    input  logic [N-1:0] rd_init,
    input  logic [N-1:0] wr_init,
    output logic         busy,
    output logic         rd_wait,
    output logic         wr_wait
);
    logic [N-1:0] rd_bits;
    logic [N-1:0] wr_bits;

    // Row state update: reset, self clear, load on issue, or drain columns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            rd_bits <= '0;
            wr_bits <= '0;
        end else if (clr_self) begin
            busy    <= 1'b0;
            rd_bits <= '0;
            wr_bits <= '0;
        end else if (load) begin
            busy    <= 1'b1;
            rd_bits <= rd_init;
            wr_bits <= wr_init;
        end else begin
            rd_bits <= rd_bits & ~clr_col;
            wr_bits <= wr_bits & ~clr_col;
        end
    end

    // Reduce the latches to one pending flag per kind.
    always_comb begin
        rd_wait = |rd_bits;
        wr_wait = |wr_bits;
    end
endmodule

// File: rtl/fudm_grant.sv
// Grant logic: turns per-unit pending flags, requests and holds into
// read and write grants.
// Assumes: purely combinational; writes also need reads resolved.
module fudm_grant #(
    parameter int unsigned N = fudm_pkg::DEF_UNITS
) (
    input  logic [N-1:0] busy,
    input  logic [N-1:0] rd_wait,
    input  logic [N-1:0] wr_wait,
    input  logic [N-1:0] rd_req,
    input  logic [N-1:0] wr_req,
    input  logic [N-1:0] hold,
    output logic [N-1:0] go_rd,
    output logic [N-1:0] go_wr
);
    // Form both grant vectors.
    always_comb begin
        go_rd = busy & rd_req & ~rd_wait;
        go_wr = busy & wr_req & ~rd_wait & ~wr_wait & ~hold;
    end
endmodule

// File: rtl/fu_dep_matrix.sv
// Function-unit hazard matrix top: accepts issues, builds the dependency
// seeds for the issuing row, clears rows and columns on done or kill,
// and produces read and write grants.
// Assumes: N >= 2; issue_unit values >= N are never accepted.
module fu_dep_matrix #(
    parameter int unsigned N    = fudm_pkg::DEF_UNITS,
    localparam int unsigned IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  logic [IDXW-1:0] issue_unit,
    input  logic [N-1:0]    issue_rd_dep,
    input  logic [N-1:0]    issue_wr_dep,
    input  logic            issue_in_order,
    input  logic [N-1:0]    rd_req,
    input  logic [N-1:0]    wr_req,
    input  logic [N-1:0]    hold,
    input  logic [N-1:0]    done,
    input  logic [N-1:0]    kill,
    output logic [N-1:0]    go_rd,
    output logic [N-1:0]    go_wr,
    output logic [N-1:0]    busy
);
    logic [N-1:0] clr_vec;
    logic [N-1:0] live;
    logic [N-1:0] rd_seed;
    logic [N-1:0] wr_seed;
    logic [N-1:0] rd_wait;
    logic [N-1:0] wr_wait;

    // Units that remain valid producers this cycle and the shared seeds.
    always_comb begin
        clr_vec = done | kill;
        live    = busy & ~clr_vec;
        rd_seed = issue_rd_dep & live;
        wr_seed = (issue_wr_dep | {N{issue_in_order}}) & live;
    end

    for (genvar r = 0; r < N; r++) begin : g_row
        logic load_r;
        logic [N-1:0] self_mask;

        // Accept the issue for this row only if it is idle and not clearing.
        always_comb begin
            self_mask    = '1;
            self_mask[r] = 1'b0;
            load_r = issue_valid && (issue_unit == IDXW'(r))
                     && !busy[r] && !clr_vec[r];
        end

        fudm_row #(.N(N)) u_row (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_r),
            .clr_self (clr_vec[r]),
            .clr_col  (clr_vec),
            .rd_init  (rd_seed & self_mask),
            .wr_init  (wr_seed & self_mask),
            .busy     (busy[r]),
            .rd_wait  (rd_wait[r]),
            .wr_wait  (wr_wait[r])
        );
    end

    fudm_grant #(.N(N)) u_grant (
        .busy    (busy),
        .rd_wait (rd_wait),
        .wr_wait (wr_wait),
        .rd_req  (rd_req),
        .wr_req  (wr_req),
        .hold    (hold),
        .go_rd   (go_rd),
        .go_wr   (go_wr)
    );
endmodule

// File: rtl/fudm_checker.sv
// Property checker for the hazard matrix, attached by bind.
// Assumes: same parameters as the bound instance.
module fudm_checker #(
    parameter int unsigned N    = fudm_pkg::DEF_UNITS,
    parameter int unsigned IDXW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            issue_valid,
    input logic [IDXW-1:0] issue_unit,
    input logic [N-1:0]    rd_req,
    input logic [N-1:0]    wr_req,
    input logic [N-1:0]    hold,
    input logic [N-1:0]    done,
    input logic [N-1:0]    kill,
    input logic [N-1:0]    go_rd,
    input logic [N-1:0]    go_wr,
    input logic [N-1:0]    busy
);
    for (genvar i = 0; i < N; i++) begin : g_chk
        a_r1_busy_from_issue: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy[i]) |-> $past(issue_valid && (issue_unit == IDXW'(i))));
        a_r3_read_grant_cause: assert property (@(posedge clk) disable iff (!rst_n)
            go_rd[i] |-> (rd_req[i] && busy[i]));
        a_r4_write_grant_cause: assert property (@(posedge clk) disable iff (!rst_n)
            go_wr[i] |-> (wr_req[i] && busy[i]));
        a_r5_hold_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
            hold[i] |-> !go_wr[i]);
        a_r6_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
            done[i] |=> !busy[i]);
        a_r7_kill_frees: assert property (@(posedge clk) disable iff (!rst_n)
            kill[i] |=> (!busy[i] && !go_wr[i]));
    end
endmodule

bind fu_dep_matrix fudm_checker #(.N(N), .IDXW(IDXW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_unit  (issue_unit),
    .rd_req      (rd_req),
    .wr_req      (wr_req),
    .hold        (hold),
    .done        (done),
    .kill        (kill),
    .go_rd       (go_rd),
    .go_wr       (go_wr),
    .busy        (busy)
);

// File: tb/sim_fu_dep_matrix.sv
module sim_fu_dep_matrix;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N = 8;
    localparam int IDXW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iv = 1'b0;
    logic [IDXW-1:0] iu = '0;
    logic [N-1:0] ird = '0, iwr = '0, rq_r = '0, rq_w = '0, hld = '0, dn = '0, kl = '0;
    logic iord = 1'b0;
    logic [N-1:0] go_rd, go_wr, busy;

    int compared = 0;
    int mismatched = 0;

    // reference model state
    bit m_busy [N];
    int rdl [N][$];
    int wrl [N][$];

    always #2 clk = ~clk;

    fu_dep_matrix #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .issue_valid(iv), .issue_unit(iu),
        .issue_rd_dep(ird), .issue_wr_dep(iwr), .issue_in_order(iord),
        .rd_req(rq_r), .wr_req(rq_w), .hold(hld), .done(dn), .kill(kl),
        .go_rd(go_rd), .go_wr(go_wr), .busy(busy)
    );

    task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        iv = 0; iu = '0; ird = '0; iwr = '0; iord = 0;
        rq_r = '0; rq_w = '0; hld = '0; dn = '0; kl = '0;
    endtask

    // model: expected outputs from current state and inputs
    task automatic cmp_model();
        logic [N-1:0] er, ew, eb;
        for (int i = 0; i < N; i++) begin
            eb[i] = m_busy[i];
            er[i] = m_busy[i] && rq_r[i] && (rdl[i].size() == 0);
            ew[i] = m_busy[i] && rq_w[i] && !hld[i] && (rdl[i].size() == 0) && (wrl[i].size() == 0);
        end
        chk("R1 busy", busy, eb);
        chk("R3 go_rd", go_rd, er);
        chk("R4 go_wr", go_wr, ew);
    endtask

    // model: advance one clock with the inputs currently applied
    task automatic model_step();
        bit acc;
        int nr[$];
        int nw[$];
        logic [N-1:0] clr;
        clr = dn | kl;
        acc = iv && (int'(iu) < N) && !m_busy[iu] && !clr[iu];
        if (acc) begin
            for (int j = 0; j < N; j++) begin
                if (j != int'(iu) && m_busy[j] && !clr[j]) begin
                    if (ird[j]) nr.push_back(j);
                    if (iwr[j] || iord) nw.push_back(j);
                end
            end
        end
        for (int i = 0; i < N; i++) begin
            if (clr[i]) begin
                m_busy[i] = 0; rdl[i].delete(); wrl[i].delete();
            end else begin
                for (int k = rdl[i].size() - 1; k >= 0; k--) if (clr[rdl[i][k]]) rdl[i].delete(k);
                for (int k = wrl[i].size() - 1; k >= 0; k--) if (clr[wrl[i][k]]) wrl[i].delete(k);
            end
        end
        if (acc) begin
            m_busy[iu] = 1; rdl[iu] = nr; wrl[iu] = nw;
        end
    endtask

    task automatic drive_begin();
        @(negedge clk);
        idle();
    endtask

    task automatic settle_tick();
        @(posedge clk);
        model_step();
    endtask

    task automatic do_issue(int u, logic [N-1:0] rd, logic [N-1:0] wr, logic ord);
        drive_begin();
        iv = 1; iu = IDXW'(u); ird = rd; iwr = wr; iord = ord;
        #1 cmp_model();
        settle_tick();
    endtask

    initial begin
        #(4 * 150000);
        mismatched++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) m_busy[i] = 0;
        idle();
        rq_r = '1; rq_w = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset leaves all idle, no grants even with requests
        chk("R9 busy", busy, 8'h00);
        chk("R9 go_rd", go_rd, 8'h00);
        chk("R9 go_wr", go_wr, 8'h00);
        rst_n = 1'b1;

        do_issue(0, 8'h00, 8'h00, 0);
        do_issue(1, 8'h01, 8'h00, 0);
        do_issue(2, 8'h26, 8'h00, 0);   // bit5 idle, bit2 self: R2

        drive_begin(); rq_r = 8'hFF; rq_w = 8'h01; hld = 8'h01;
        #1 cmp_model();
        chk("R3 chain read", go_rd, 8'h01);
        chk("R5 hold blocks write", go_wr, 8'h00);
        settle_tick();

        drive_begin(); rq_r = 8'hFF; rq_w = 8'h01;
        #1 cmp_model();
        chk("R4 write granted", go_wr, 8'h01);
        settle_tick();

        drive_begin(); rq_r = 8'hFF; dn = 8'h01;
        #1 cmp_model();
        chk("R6 before release", go_rd, 8'h01);
        settle_tick();

        drive_begin(); rq_r = 8'hFF;
        #1 cmp_model();
        chk("R6 dependent released", go_rd, 8'h02);
        chk("R6 busy", busy, 8'h06);
        settle_tick();

        drive_begin(); dn = 8'h02; #1 cmp_model(); settle_tick();
        drive_begin(); rq_r = 8'hFF;
        #1 cmp_model();
        chk("R2 idle and self bits ignored", go_rd, 8'h04);
        settle_tick();

        do_issue(3, 8'h04, 8'h00, 0);
        drive_begin(); kl = 8'h44; #1 cmp_model(); settle_tick();
        drive_begin(); rq_r = 8'hFF;
        #1 cmp_model();
        chk("R7 kill releases", go_rd, 8'h08);
        chk("R7 busy after kill", busy, 8'h08);
        settle_tick();

        do_issue(4, 8'h00, 8'h00, 1);
        drive_begin(); rq_w = 8'h18;
        #1 cmp_model();
        chk("R8 oldest writes", go_wr, 8'h08);
        settle_tick();
        drive_begin(); dn = 8'h08; #1 cmp_model(); settle_tick();
        drive_begin(); rq_w = 8'h18;
        #1 cmp_model();
        chk("R8 next writes", go_wr, 8'h10);
        settle_tick();

        do_issue(7, 8'h00, 8'h00, 0);
        do_issue(4, 8'h80, 8'h00, 0);   // busy target: ignored
        drive_begin(); rq_r = 8'h90;
        #1 cmp_model();
        chk("R1 reissue ignored", go_rd, 8'h90);
        chk("R1 busy", busy, 8'h90);
        settle_tick();

        drive_begin(); dn = 8'hFF; #1 cmp_model(); settle_tick();
        drive_begin(); #1 cmp_model();
        chk("R6 all free", busy, 8'h00);
        settle_tick();

        // pseudo-random traffic against the model (R1..R8)
        for (int c = 0; c < 4000; c++) begin
            drive_begin();
            iv   = ($urandom % 3) == 0;
            iu   = IDXW'($urandom);
            ird  = N'($urandom) & N'($urandom);
            iwr  = N'($urandom) & N'($urandom);
            iord = ($urandom % 4) == 0;
            rq_r = N'($urandom);
            rq_w = N'($urandom);
            hld  = N'($urandom) & N'($urandom);
            dn   = N'($urandom) & N'($urandom) & N'($urandom);
            kl   = (($urandom % 8) == 0) ? N'($urandom) & N'($urandom) : '0;
            if (c % 500 == 499) dn = '1;
            #1 cmp_model();
            settle_tick();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule